// File: doc/BRIEF.md
# ALU Operand Mode Decoder

This block turns the addressing-mode nibble, the destination field and the 16-bit operand tail of an ALU-format instruction into the control signals an execution stage needs to fetch its right-hand operand. Its outputs are the register selects, the operation width, a decoded immediate or a type-scaled memory offset, an operand-kind code, the shift count, the pointer step control, a request for a trailing 32-bit literal word, and an illegal-instruction flag. It reads no registers and computes no addresses. It only says which ones to use and how.

Each accepted instruction is decoded through one register stage. When `in_valid` is high at a rising clock edge, the decoded fields appear on the outputs after that edge, and `out_valid` is high for that one cycle. While `in_valid` is low the outputs keep their last decoded values.

Within the operand tail, the left source register S sits in bits 15:12, the second register R in bits 11:8, the type code in bits 7:5 and the extended-bank bit x in bit 4, for every mode that carries those fields. A register select is five bits wide. Bit 4 set means the extended bank (0x10 is the condition codes, 0x11 is the link register). Bit 4 clear means a general register, given by its index.

Top module: `alu_operand_decoder`

## Requirements
- R1: After reset, `out_valid`, `illegal` and `need_word` are 0. `out_valid` is 1 in exactly the cycle that follows a clock edge with `in_valid` high, and while `in_valid` stays low every other output holds its value.
- R2: Mode 0 gives `imm` as the tail zero-extended. Mode 1 gives the tail with bits 31:16 forced to ones. Mode 2 gives tail bits 11:0 sign-extended with `lhs_sel` = S. In modes 0 to 2 `kind` = 0 (immediate) and `opnd_type` = 4 (32-bit).
- R3: Mode 3 takes the 8-bit value {tail[11:8], tail[3:0]} and gives it sign-extended in `imm` with `lhs_sel` = S. The value 0x80 instead sets `need_word` and gives `imm` = 0.
- R4: Mode 4 gives `kind` = 1, `lhs_sel` = S, `rhs_sel` = R, `shamt` = tail[2:0] and `imm` = 0. Mode 6 gives `kind` = 3, `lhs_sel` = D, base `rhs_sel` = S, index `idx_sel` = R and `shamt` = tail[2:0].
- R5: Mode 5 gives `kind` = 2 with base `rhs_sel` = R and `step` = tail[2:0] (0 pre-increment, 1 pre-decrement, 2 post-increment, 3 post-decrement, 4 no change). Step codes 5 to 7 raise `illegal`. Every other mode outputs `step` = 4.
- R6: Mode 7 gives `kind` = 4 and `imm` = (0xFFFFFFE0 | tail[4:0]) times the type size. A zero 5-bit field sets `need_word` and gives `imm` = 0.
- R7: Modes 8, 9, A and B give `kind` = 4 and `imm` = (tail[4:0] + 32·k) times the type size, where k = mode − 8. Here `lhs_sel` = S and `rhs_sel` = R.
- R8: Mode C gives `imm` = {tail[15:12], tail[4:0]} times the type size. Mode D adds 512 to that field before the scaling. Both give `kind` = 4, `lhs_sel` = D and `rhs_sel` = R.
- R9: Mode E gives `kind` = 5 (double indirection) with the same 9-bit scaled offset as mode C. A field value of 0x1F sets `need_word` and gives `imm` = 0.
- R10: `opnd_type` is tail[7:5] in modes 3 to E. Types 0 and 1 have size 1, types 2 and 3 have size 2, and type 4 has size 4. Types 5 to 7 raise `illegal`.
- R11: In modes 3 to 6 with x = 1, every register field the mode uses is mapped through the extended bank: index 0 gives 0x10, index 1 gives 0x11, and indices 13 to 15 give general registers 13 to 15. Indices 2 to 12 raise `illegal`. With x = 0, or in any other mode, selects are general.
- R12: Mode F raises `illegal` and gives `kind` = 7 with all selects zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields present this cycle |
| in_mode | input | 4 | Addressing-mode nibble |
| in_dst | input | 4 | Destination register field |
| in_tail | input | 16 | Operand tail following the destination field |
| out_valid | output | 1 | Decoded outputs belong to a new instruction |
| dst_sel | output | 5 | Destination register select |
| lhs_sel | output | 5 | Left operand register select |
| rhs_sel | output | 5 | Shifted register, or memory base register |
| idx_sel | output | 5 | Index register for the scaled-index mode |
| shamt | output | 3 | Left shift applied to the second register |
| step | output | 3 | Base register pre/post step code |
| kind | output | 3 | Operand kind: 0 imm, 1 reg, 2 step, 3 index, 4 offset, 5 indirect, 7 none |
| opnd_type | output | 3 | Operand type code |
| imm | output | 32 | Immediate value, or byte offset |
| need_word | output | 1 | A 32-bit literal word follows the instruction |
| illegal | output | 1 | Reserved mode, type, step or extended register |

## Verification
Any fault in the single decode stage shows at the ports one cycle after the offending instruction is accepted. A mis-steered offset scaling produces a byte offset that is off by a factor of two or four. A wrong bank base shows as an offset that is 32, 64, 96 or 512 elements too small. A missed escape appears as a nonzero `imm` paired with `need_word`, or as `need_word` staying low. Because held outputs must not move while `in_valid` is low, a register stage that captures when it should not is seen in the very next idle cycle.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

  localparam int SEL_W  = 5;
  localparam int FLD_W  = 4;
  localparam int TAIL_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    KIND_IMM      = 3'd0,
    KIND_REG      = 3'd1,
    KIND_STEP     = 3'd2,
    KIND_INDEX    = 3'd3,
    KIND_OFFSET   = 3'd4,
    KIND_INDIRECT = 3'd5,
    KIND_NONE     = 3'd7
  } opnd_kind_e;

  localparam logic [2:0] TYPE_WORD  = 3'd4;
  localparam logic [2:0] STEP_PLAIN = 3'd4;

  // log2 of the element size for a type code
  function automatic logic [1:0] type_shift(input logic [2:0] t);
    case (t)
      3'd0, 3'd1: type_shift = 2'd0;
      3'd2, 3'd3: type_shift = 2'd1;
      default:    type_shift = 2'd2;
    endcase
  endfunction

  // element count to byte offset
  function automatic logic [WORD_W-1:0] scale_elems(input logic [WORD_W-1:0] n,
                                                    input logic [1:0] sh);
    scale_elems = n << sh;
  endfunction

  function automatic logic [WORD_W-1:0] sext8(input logic [7:0] v);
    sext8 = {{(WORD_W-8){v[7]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] sext12(input logic [11:0] v);
    sext12 = {{(WORD_W-12){v[11]}}, v};
  endfunction

endpackage

// File: rtl/alu_reg_map.sv
module alu_reg_map
  import alu_dec_pkg::*;
(
  input  logic [FLD_W-1:0] fld,
  input  logic             ext_en,
  output logic [SEL_W-1:0] sel,
  output logic             reserved
);
  localparam logic [FLD_W-1:0] FIRST_ALIAS = FLD_W'(13);

  always_comb begin
    sel      = {1'b0, fld};
    reserved = 1'b0;
    if (ext_en) begin
      if (fld >= FIRST_ALIAS) begin
        sel = {1'b0, fld};
      end else if (fld < FLD_W'(2)) begin
        sel = {1'b1, fld};
      end else begin
        sel      = '0;
        reserved = 1'b1;
      end
    end
  end
endmodule

// File: rtl/alu_imm_gen.sv
module alu_imm_gen
  import alu_dec_pkg::*;
(
  input  logic [3:0]        mode,
  input  logic [TAIL_W-1:0] tail,
  input  logic [1:0]        tsh,
  output logic [WORD_W-1:0] imm,
  output logic              need_word
);
  logic [4:0] f5;
  logic [8:0] f9;
  logic [7:0] i8;

  assign f5 = tail[4:0];
  assign f9 = {tail[15:12], tail[4:0]};
  assign i8 = {tail[11:8], tail[3:0]};

  always_comb begin
    imm       = '0;
    need_word = 1'b0;
    case (mode)
      4'h0: imm = {{(WORD_W-TAIL_W){1'b0}}, tail};
      4'h1: imm = {{(WORD_W-TAIL_W){1'b1}}, tail};
      4'h2: imm = sext12(tail[11:0]);
      4'h3: begin
        need_word = (i8 == 8'h80);
        imm       = need_word ? '0 : sext8(i8);
      end
      4'h7: begin
        need_word = (f5 == 5'd0);
        imm       = need_word ? '0
                  : scale_elems({{(WORD_W-5){1'b1}}, f5}, tsh);
      end
      4'h8, 4'h9, 4'hA, 4'hB:
        imm = scale_elems({{(WORD_W-7){1'b0}}, mode[1:0], f5}, tsh);
      4'hC: imm = scale_elems({{(WORD_W-9){1'b0}}, f9}, tsh);
      4'hD: imm = scale_elems({{(WORD_W-10){1'b0}}, 1'b1, f9}, tsh);
      4'hE: begin
        need_word = (f9 == 9'h01F);
        imm       = need_word ? '0
                  : scale_elems({{(WORD_W-9){1'b0}}, f9}, tsh);
      end
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/alu_mode_ctl.sv
module alu_mode_ctl
  import alu_dec_pkg::*;
(
  input  logic [3:0]       mode,
  input  logic [2:0]       tfld,
  input  logic [2:0]       lo3,
  input  logic [SEL_W-1:0] d_sel,
  input  logic [SEL_W-1:0] s_sel,
  input  logic [SEL_W-1:0] r_sel,
  input  logic             d_rsv,
  input  logic             s_rsv,
  input  logic             r_rsv,
  output opnd_kind_e       kind,
  output logic [SEL_W-1:0] dst,
  output logic [SEL_W-1:0] lhs,
  output logic [SEL_W-1:0] rhs,
  output logic [SEL_W-1:0] idx,
  output logic [2:0]       shamt,
  output logic [2:0]       step,
  output logic [2:0]       otype,
  output logic             rsv_hit,
  output logic             bad_field
);
  logic uses_type;

  assign uses_type = (mode >= 4'h3) && (mode <= 4'hE);
  assign otype     = uses_type ? tfld : TYPE_WORD;

  always_comb begin
    kind      = KIND_IMM;
    dst       = d_sel;
    lhs       = s_sel;
    rhs       = '0;
    idx       = '0;
    shamt     = '0;
    step      = STEP_PLAIN;
    rsv_hit   = 1'b0;
    bad_field = uses_type && (tfld > TYPE_WORD);
    case (mode)
      4'h0, 4'h1: lhs = d_sel;
      4'h2: ;
      4'h3: rsv_hit = d_rsv | s_rsv;
      4'h4: begin
        kind    = KIND_REG;
        rhs     = r_sel;
        shamt   = lo3;
        rsv_hit = d_rsv | s_rsv | r_rsv;
      end
      4'h5: begin
        kind    = KIND_STEP;
        rhs     = r_sel;
        step    = lo3;
        rsv_hit = d_rsv | s_rsv | r_rsv;
        if (lo3 > STEP_PLAIN) bad_field = 1'b1;
      end
      4'h6: begin
        kind    = KIND_INDEX;
        lhs     = d_sel;
        rhs     = s_sel;
        idx     = r_sel;
        shamt   = lo3;
        rsv_hit = d_rsv | s_rsv | r_rsv;
      end
      4'h7, 4'h8, 4'h9, 4'hA, 4'hB: begin
        kind = KIND_OFFSET;
        rhs  = r_sel;
      end
      4'hC, 4'hD: begin
        kind = KIND_OFFSET;
        lhs  = d_sel;
        rhs  = r_sel;
      end
      4'hE: begin
        kind = KIND_INDIRECT;
        lhs  = d_sel;
        rhs  = r_sel;
      end
      default: begin
        kind      = KIND_NONE;
        dst       = '0;
        lhs       = '0;
        bad_field = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/alu_operand_decoder.sv
module alu_operand_decoder
  import alu_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_mode,
  input  logic [FLD_W-1:0]  in_dst,
  input  logic [TAIL_W-1:0] in_tail,
  output logic              out_valid,
  output logic [SEL_W-1:0]  dst_sel,
  output logic [SEL_W-1:0]  lhs_sel,
  output logic [SEL_W-1:0]  rhs_sel,
  output logic [SEL_W-1:0]  idx_sel,
  output logic [2:0]        shamt,
  output logic [2:0]        step,
  output logic [2:0]        kind,
  output logic [2:0]        opnd_type,
  output logic [WORD_W-1:0] imm,
  output logic              need_word,
  output logic              illegal
);
  localparam int NREG = 3;

  logic             ext_en;
  logic [FLD_W-1:0] fld [NREG];
  logic [SEL_W-1:0] msel [NREG];
  logic             mrsv [NREG];

  assign ext_en = (in_mode >= 4'h3) && (in_mode <= 4'h6) && in_tail[4];
  assign fld[0] = in_dst;
  assign fld[1] = in_tail[15:12];
  assign fld[2] = in_tail[11:8];

  for (genvar g = 0; g < NREG; g++) begin : g_map
    alu_reg_map i_map (
      .fld      (fld[g]),
      .ext_en   (ext_en),
      .sel      (msel[g]),
      .reserved (mrsv[g])
    );
  end

  opnd_kind_e       nx_kind;
  logic [SEL_W-1:0] nx_dst, nx_lhs, nx_rhs, nx_idx;
  logic [2:0]       nx_shamt, nx_step, nx_type;
  logic             rsv_hit, bad_field;
  logic [WORD_W-1:0] nx_imm;
  logic             nx_word;
  logic             nx_illegal;

  alu_mode_ctl i_ctl (
    .mode      (in_mode),
    .tfld      (in_tail[7:5]),
    .lo3       (in_tail[2:0]),
    .d_sel     (msel[0]),
    .s_sel     (msel[1]),
    .r_sel     (msel[2]),
    .d_rsv     (mrsv[0]),
    .s_rsv     (mrsv[1]),
    .r_rsv     (mrsv[2]),
    .kind      (nx_kind),
    .dst       (nx_dst),
    .lhs       (nx_lhs),
    .rhs       (nx_rhs),
    .idx       (nx_idx),
    .shamt     (nx_shamt),
    .step      (nx_step),
    .otype     (nx_type),
    .rsv_hit   (rsv_hit),
    .bad_field (bad_field)
  );

  alu_imm_gen i_imm (
    .mode      (in_mode),
    .tail      (in_tail),
    .tsh       (type_shift(nx_type)),
    .imm       (nx_imm),
    .need_word (nx_word)
  );

  assign nx_illegal = rsv_hit | bad_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_sel   <= '0;
      lhs_sel   <= '0;
      rhs_sel   <= '0;
      idx_sel   <= '0;
      shamt     <= '0;
      step      <= STEP_PLAIN;
      kind      <= KIND_NONE;
      opnd_type <= TYPE_WORD;
      imm       <= '0;
      need_word <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_sel   <= nx_dst;
        lhs_sel   <= nx_lhs;
        rhs_sel   <= nx_rhs;
        idx_sel   <= nx_idx;
        shamt     <= nx_shamt;
        step      <= nx_step;
        kind      <= nx_kind;
        opnd_type <= nx_type;
        imm       <= nx_imm;
        need_word <= nx_word;
        illegal   <= nx_illegal;
      end
    end
  end
endmodule

// File: rtl/alu_dec_chk.sv
module alu_dec_chk
  import alu_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              rsv_hit,
  input logic              out_valid,
  input logic [SEL_W-1:0]  dst_sel,
  input logic [SEL_W-1:0]  idx_sel,
  input logic [2:0]        kind,
  input logic [2:0]        opnd_type,
  input logic [WORD_W-1:0] imm,
  input logic              need_word,
  input logic              illegal
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(imm) && $stable(dst_sel) && $stable(illegal));

  assert_escape_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && need_word |-> imm == '0);

  assert_regshift_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && kind == 3'd1 |-> imm == '0 && idx_sel == '0);

  assert_type_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !illegal |-> opnd_type <= 3'd4);

  assert_reserved_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rsv_hit |=> illegal);

  assert_none_illegal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && kind == 3'd7 |-> illegal);
endmodule

bind alu_operand_decoder alu_dec_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .rsv_hit   (rsv_hit),
  .out_valid (out_valid),
  .dst_sel   (dst_sel),
  .idx_sel   (idx_sel),
  .kind      (kind),
  .opnd_type (opnd_type),
  .imm       (imm),
  .need_word (need_word),
  .illegal   (illegal)
);

// File: tb/test_alu_operand_decoder.sv
module test_alu_operand_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_mode = '0;
  logic [3:0]  in_dst = '0;
  logic [15:0] in_tail = '0;
  logic        out_valid;
  logic [4:0]  dst_sel, lhs_sel, rhs_sel, idx_sel;
  logic [2:0]  shamt, step, kind, opnd_type;
  logic [31:0] imm;
  logic        need_word, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_operand_decoder i_alu_operand_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_dst(in_dst), .in_tail(in_tail), .out_valid(out_valid),
    .dst_sel(dst_sel), .lhs_sel(lhs_sel), .rhs_sel(rhs_sel), .idx_sel(idx_sel),
    .shamt(shamt), .step(step), .kind(kind), .opnd_type(opnd_type),
    .imm(imm), .need_word(need_word), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int elem_size(input int t);
    return (t < 2) ? 1 : (t < 4) ? 2 : 4;
  endfunction

  // present one instruction, return after the decoded result is on the outputs
  task automatic send(input logic [3:0] m, input logic [3:0] d, input logic [15:0] t);
    @(negedge clk);
    in_mode  = m;
    in_dst   = d;
    in_tail  = t;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset out_valid", {31'd0, out_valid}, 0);
    chk("R1 reset illegal", {31'd0, illegal}, 0);
    chk("R1 reset need_word", {31'd0, need_word}, 0);
  endtask

  task automatic t_immediates;
    send(4'h0, 4'd3, 16'hBEEF);
    chk("R1 out_valid", {31'd0, out_valid}, 1);
    chk("R2 mode0 imm", imm, 32'h0000BEEF);
    chk("R2 mode0 lhs", {27'd0, lhs_sel}, 3);
    chk("R2 mode0 kind", {29'd0, kind}, 0);
    chk("R2 mode0 type", {29'd0, opnd_type}, 4);
    send(4'h1, 4'd3, 16'h1234);
    chk("R2 mode1 imm", imm, 32'hFFFF1234);
    send(4'h2, 4'd1, 16'h5800);
    chk("R2 mode2 imm", imm, 32'hFFFFF800);
    chk("R2 mode2 lhs", {27'd0, lhs_sel}, 5);
  endtask

  task automatic t_byte_imm;
    send(4'h3, 4'd1, 16'h278F);
    chk("R3 mode3 imm", imm, 32'h0000007F);
    chk("R3 mode3 no word", {31'd0, need_word}, 0);
    send(4'h3, 4'd1, 16'h2C81);
    chk("R3 mode3 negative", imm, 32'hFFFFFFC1);
    send(4'h3, 4'd1, 16'h2880);
    chk("R3 escape word", {31'd0, need_word}, 1);
    chk("R3 escape imm", imm, 0);
  endtask

  task automatic t_reg_forms;
    send(4'h4, 4'd7, 16'h1283);
    chk("R4 mode4 kind", {29'd0, kind}, 1);
    chk("R4 mode4 rhs", {27'd0, rhs_sel}, 2);
    chk("R4 mode4 shamt", {29'd0, shamt}, 3);
    chk("R4 mode4 imm", imm, 0);
    send(4'h6, 4'd4, 16'h7982);
    chk("R4 mode6 kind", {29'd0, kind}, 3);
    chk("R4 mode6 lhs", {27'd0, lhs_sel}, 4);
    chk("R4 mode6 base", {27'd0, rhs_sel}, 7);
    chk("R4 mode6 index", {27'd0, idx_sel}, 9);
    chk("R4 mode6 shamt", {29'd0, shamt}, 2);
  endtask

  task automatic t_steps;
    for (int s = 0; s < 8; s++) begin
      send(4'h5, 4'd0, 16'h1280 | 16'(s));
      chk("R5 step kind", {29'd0, kind}, 2);
      chk("R5 step base", {27'd0, rhs_sel}, 2);
      if (s <= 4) chk("R5 step code", {29'd0, step}, 32'(s));
      chk("R5 step legality", {31'd0, illegal}, (s > 4) ? 1 : 0);
    end
    send(4'h8, 4'd0, 16'h1285);
    chk("R5 default step", {29'd0, step}, 4);
  endtask

  task automatic t_neg_offset;
    send(4'h7, 4'd0, 16'h1243);
    chk("R6 mode7 offset", imm, 32'((-32 + 3) * elem_size(2)));
    chk("R6 mode7 kind", {29'd0, kind}, 4);
    send(4'h7, 4'd0, 16'h1280);
    chk("R6 escape word", {31'd0, need_word}, 1);
    chk("R6 escape imm", imm, 0);
  endtask

  task automatic t_banks;
    for (int k = 0; k < 4; k++) begin
      send(4'(8 + k), 4'd0, 16'h1285);
      chk("R7 bank offset", imm, 32'((5 + 32 * k) * elem_size(4)));
      chk("R7 bank lhs", {27'd0, lhs_sel}, 1);
    end
    send(4'h9, 4'd0, 16'h1225);
    chk("R7 byte scale", imm, 32'((5 + 32) * elem_size(1)));
  endtask

  task automatic t_long_offset;
    send(4'hC, 4'd6, 16'hD32B);
    chk("R8 modeC offset", imm, 32'(427 * elem_size(1)));
    chk("R8 modeC lhs", {27'd0, lhs_sel}, 6);
    chk("R8 modeC base", {27'd0, rhs_sel}, 3);
    send(4'hD, 4'd6, 16'hD36B);
    chk("R8 modeD offset", imm, 32'((427 + 512) * elem_size(3)));
  endtask

  task automatic t_indirect;
    send(4'hE, 4'd2, 16'h1381);
    chk("R9 indirect kind", {29'd0, kind}, 5);
    chk("R9 indirect offset", imm, 32'(33 * elem_size(4)));
    send(4'hE, 4'd2, 16'h039F);
    chk("R9 escape word", {31'd0, need_word}, 1);
    chk("R9 escape imm", imm, 0);
  endtask

  task automatic t_types;
    send(4'h8, 4'd0, 16'h12C1);
    chk("R10 reserved type", {31'd0, illegal}, 1);
    send(4'h8, 4'd0, 16'h1261);
    chk("R10 type code", {29'd0, opnd_type}, 3);
    chk("R10 legal type", {31'd0, illegal}, 0);
  endtask

  task automatic t_ext_regs;
    send(4'h3, 4'd0, 16'h1090);
    chk("R11 ext cc", {27'd0, dst_sel}, 32'h10);
    chk("R11 ext link", {27'd0, lhs_sel}, 32'h11);
    chk("R11 ext legal", {31'd0, illegal}, 0);
    send(4'h3, 4'd14, 16'hF090);
    chk("R11 alias dst", {27'd0, dst_sel}, 14);
    chk("R11 alias lhs", {27'd0, lhs_sel}, 15);
    send(4'h4, 4'd13, 16'hD591);
    chk("R11 reserved R", {31'd0, illegal}, 1);
    send(4'h4, 4'd1, 16'h1281);
    chk("R11 no x general", {27'd0, dst_sel}, 1);
    chk("R11 no x legal", {31'd0, illegal}, 0);
    send(4'h8, 4'd5, 16'h1291);
    chk("R11 x ignored mode8", {31'd0, illegal}, 0);
    chk("R11 x ignored dst", {27'd0, dst_sel}, 5);
  endtask

  task automatic t_reserved_mode;
    send(4'hF, 4'd3, 16'h1234);
    chk("R12 modeF illegal", {31'd0, illegal}, 1);
    chk("R12 modeF kind", {29'd0, kind}, 7);
    chk("R12 modeF dst", {27'd0, dst_sel}, 0);
  endtask

  task automatic t_hold;
    send(4'h0, 4'd9, 16'h00AA);
    @(negedge clk);
    in_mode = 4'h1;
    in_dst  = 4'd2;
    in_tail = 16'h5555;
    @(negedge clk);
    chk("R1 idle valid", {31'd0, out_valid}, 0);
    chk("R1 idle imm hold", imm, 32'h000000AA);
    chk("R1 idle dst hold", {27'd0, dst_sel}, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_immediates();
    t_byte_imm();
    t_reg_forms();
    t_steps();
    t_neg_offset();
    t_banks();
    t_long_offset();
    t_indirect();
    t_types();
    t_ext_regs();
    t_reserved_mode();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule